// File: doc/BRIEF.md
# Cross-Element Forwarding Ring

This block lets a loop-carried value pass from one iteration to the next without a trip through memory. Iteration `i` runs on processing element `i`. Each element sends one word to the element with the next higher index over a valid/ready port. That element takes the word from its own valid/ready receive port. A receive port shows nothing until the word from the previous element has arrived. Only the operation that consumes the word waits; the element can do other work meanwhile. Each hop holds a small first-in first-out queue, so several elements can have iterations in flight at the same time.

A controller starts the chain. It pulses `ctl_init` to empty every hop queue and to latch the active element count. It then writes a seed word, which element 0 receives as its "previous" value. The last active element sends its result to a controller read port and not onward. When the active count is smaller than the physical element count, the elements above it take no part.

Top module: `xring`

## Requirements
- R1: After synchronous reset every hop is empty: `elem_rx_valid` is all zero, `ctl_rd_valid` is 0, `ctl_wr_ready` is 1, and the active element count equals `NUM_ELEM`, so every `elem_tx_ready` is 1.
- R2: A word accepted on the controller write port (`ctl_wr_valid && ctl_wr_ready` at a clock edge) appears on element 0's receive port from the next cycle.
- R3: A word sent by element k, where k+1 is below the active count, is delivered only to element k+1's receive port, visible from the cycle after it was accepted.
- R4: A word sent by the last active element (index count−1) goes to the controller read port and to no element.
- R5: An element whose index is at or above the active count never asserts receive-valid, and its send-ready stays 0.
- R6: Each hop holds at most 2 words. The ready toward a hop's producer is 0 whenever that hop already holds 2 words, even if the consumer takes one in the same cycle.
- R7: Words leave each hop in the order in which they entered it.
- R8: A receive port (element or controller) is valid only while its hop holds a word. Its data stays unchanged until the word is taken.
- R9: In a cycle with `ctl_init` high, every ready and valid output is 0. From the next cycle all hops are empty. The active count becomes `ctl_vlen` clamped to the range 1..`NUM_ELEM`, so a value of 0 selects 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctl_init | input | 1 | Clears all hops and latches the active count |
| ctl_vlen | input | $clog2(NUM_ELEM+1) | Requested active element count, sampled with `ctl_init` |
| ctl_wr_valid | input | 1 | Seed word offered to element 0 |
| ctl_wr_ready | output | 1 | Seed hop can accept a word |
| ctl_wr_data | input | DATA_W | Seed word |
| ctl_rd_valid | output | 1 | Tail hop holds a word |
| ctl_rd_ready | input | 1 | Controller takes the tail word |
| ctl_rd_data | output | DATA_W | Oldest tail word |
| elem_tx_valid | input | NUM_ELEM | Per-element send request |
| elem_tx_ready | output | NUM_ELEM | Per-element send acceptance |
| elem_tx_data | input | NUM_ELEM*DATA_W | Per-element send words, element k at bits k*DATA_W |
| elem_rx_valid | output | NUM_ELEM | Per-element word available from previous element |
| elem_rx_ready | input | NUM_ELEM | Per-element consume |
| elem_rx_data | output | NUM_ELEM*DATA_W | Per-element received words, element k at bits k*DATA_W |

## Verification
A corrupted hop count or pointer shows at the ports within a cycle or two. The word on a receive port is then stale, duplicated or out of order, or a ready stays high on a full hop. The bench keeps a queue per hop and compares every ready, valid and data output on every clock, so the first such cycle is caught. A wrong route shows on the first word sent after `ctl_init`: the word turns up on the wrong receive port, or a count it should not reach wakes an element.

// File: rtl/xring_pkg.sv
package xring_pkg;

  // Active element count after clamping a request into 1..n.
  function automatic int clamp_len(int req, int n);
    if (req < 1) return 1;
    if (req > n) return n;
    return req;
  endfunction

  // Hop that element k feeds: k+1 inside the chain, n (tail) for the
  // last active element, n+1 meaning "no hop" above the active count.
  function automatic int dest_hop(int k, int vlen, int n);
    if (k + 1 < vlen)  return k + 1;
    if (k + 1 == vlen) return n;
    return n + 1;
  endfunction

  // Circular pointer advance for a queue of the given depth.
  function automatic int ptr_next(int p, int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Occupancy after one cycle of push/pop.
  function automatic int next_count(int cnt, bit push, bit pop);
    return cnt + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/xring_fifo.sv
module xring_fifo
  import xring_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  output logic         in_ready,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic         out_valid,
  output logic [W-1:0] rdata
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign in_ready  = (count != CNT_W'(DEPTH));
  assign out_valid = (count != '0);
  assign rdata     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(ptr_next(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(ptr_next(int'(rd_ptr), DEPTH));
      count <= CNT_W'(next_count(int'(count), push, pop));
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr] <= wdata;
  end

  assert_cap_R6: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    push |-> in_ready);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !pop && !clr) |=> (out_valid && $stable(rdata)));

endmodule

// File: rtl/xring_route.sv
module xring_route
  import xring_pkg::*;
#(
  parameter int N  = 4,
  parameter int W  = 32,
  parameter int LW = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                block,
  input  logic [LW-1:0]       vlen,
  input  logic                ctl_wr_valid,
  output logic                ctl_wr_ready,
  input  logic [W-1:0]        ctl_wr_data,
  input  logic [N-1:0]        tx_valid,
  output logic [N-1:0]        tx_ready,
  input  logic [N*W-1:0]      tx_data,
  input  logic [N:0]          hop_ready,
  output logic [N:0]          hop_push,
  output logic [N:0][W-1:0]   hop_wdata
);

  logic [N-1:0] tx_fire;

  always_comb begin
    int d;
    ctl_wr_ready = !block && hop_ready[0];
    hop_push     = '0;
    hop_wdata    = '0;
    tx_ready     = '0;
    hop_push[0]  = ctl_wr_valid && ctl_wr_ready;
    hop_wdata[0] = ctl_wr_data;
    for (int k = 0; k < N; k++) begin
      d = dest_hop(k, int'(vlen), N);
      for (int j = 1; j <= N; j++) begin
        if (j == d) begin
          tx_ready[k]  = !block && hop_ready[j];
          hop_push[j]  = tx_valid[k] && !block && hop_ready[j];
          hop_wdata[j] = tx_data[k*W +: W];
        end
      end
    end
  end

  assign tx_fire = tx_valid & tx_ready;

  assert_hop_balance_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(tx_fire) == $countones(hop_push[N:1]));

endmodule

// File: rtl/xring_drain.sv
module xring_drain #(
  parameter int N  = 4,
  parameter int W  = 32,
  parameter int LW = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                block,
  input  logic [LW-1:0]       vlen,
  input  logic [N:0]          hop_valid,
  input  logic [N:0][W-1:0]   hop_rdata,
  output logic [N:0]          hop_pop,
  output logic [N-1:0]        rx_valid,
  input  logic [N-1:0]        rx_ready,
  output logic [N*W-1:0]      rx_data,
  output logic                ctl_rd_valid,
  input  logic                ctl_rd_ready,
  output logic [W-1:0]        ctl_rd_data
);

  always_comb begin
    hop_pop = '0;
    rx_data = '0;
    for (int k = 0; k < N; k++) begin
      rx_valid[k]        = !block && (k < int'(vlen)) && hop_valid[k];
      rx_data[k*W +: W]  = hop_rdata[k];
      hop_pop[k]         = rx_valid[k] && rx_ready[k];
    end
    ctl_rd_valid = !block && hop_valid[N];
    ctl_rd_data  = hop_rdata[N];
    hop_pop[N]   = ctl_rd_valid && ctl_rd_ready;
  end

  assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (rst)
    (hop_pop & ~hop_valid) == '0);

endmodule

// File: rtl/xring.sv
module xring
  import xring_pkg::*;
#(
  parameter int NUM_ELEM  = 4,
  parameter int DATA_W    = 32,
  parameter int HOP_DEPTH = 2,
  localparam int LEN_W    = $clog2(NUM_ELEM + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ctl_init,
  input  logic [LEN_W-1:0]           ctl_vlen,
  input  logic                       ctl_wr_valid,
  output logic                       ctl_wr_ready,
  input  logic [DATA_W-1:0]          ctl_wr_data,
  output logic                       ctl_rd_valid,
  input  logic                       ctl_rd_ready,
  output logic [DATA_W-1:0]          ctl_rd_data,
  input  logic [NUM_ELEM-1:0]        elem_tx_valid,
  output logic [NUM_ELEM-1:0]        elem_tx_ready,
  input  logic [NUM_ELEM*DATA_W-1:0] elem_tx_data,
  output logic [NUM_ELEM-1:0]        elem_rx_valid,
  input  logic [NUM_ELEM-1:0]        elem_rx_ready,
  output logic [NUM_ELEM*DATA_W-1:0] elem_rx_data
);

  localparam int NHOP = NUM_ELEM + 1;

  logic [LEN_W-1:0]                vlen_q;
  logic [NUM_ELEM:0]               hop_push, hop_ready, hop_valid, hop_pop;
  logic [NUM_ELEM:0][DATA_W-1:0]   hop_wdata, hop_rdata;

  always_ff @(posedge clk) begin
    if (rst)           vlen_q <= LEN_W'(NUM_ELEM);
    else if (ctl_init) vlen_q <= LEN_W'(clamp_len(int'(ctl_vlen), NUM_ELEM));
  end

  for (genvar h = 0; h < NHOP; h++) begin : g_hop
    xring_fifo #(.W(DATA_W), .DEPTH(HOP_DEPTH)) u_q (
      .clk      (clk),
      .rst      (rst),
      .clr      (ctl_init),
      .push     (hop_push[h]),
      .in_ready (hop_ready[h]),
      .wdata    (hop_wdata[h]),
      .pop      (hop_pop[h]),
      .out_valid(hop_valid[h]),
      .rdata    (hop_rdata[h])
    );
  end

  xring_route #(.N(NUM_ELEM), .W(DATA_W), .LW(LEN_W)) u_route (
    .clk         (clk),
    .rst         (rst),
    .block       (ctl_init),
    .vlen        (vlen_q),
    .ctl_wr_valid(ctl_wr_valid),
    .ctl_wr_ready(ctl_wr_ready),
    .ctl_wr_data (ctl_wr_data),
    .tx_valid    (elem_tx_valid),
    .tx_ready    (elem_tx_ready),
    .tx_data     (elem_tx_data),
    .hop_ready   (hop_ready),
    .hop_push    (hop_push),
    .hop_wdata   (hop_wdata)
  );

  xring_drain #(.N(NUM_ELEM), .W(DATA_W), .LW(LEN_W)) u_drain (
    .clk         (clk),
    .rst         (rst),
    .block       (ctl_init),
    .vlen        (vlen_q),
    .hop_valid   (hop_valid),
    .hop_rdata   (hop_rdata),
    .hop_pop     (hop_pop),
    .rx_valid    (elem_rx_valid),
    .rx_ready    (elem_rx_ready),
    .rx_data     (elem_rx_data),
    .ctl_rd_valid(ctl_rd_valid),
    .ctl_rd_ready(ctl_rd_ready),
    .ctl_rd_data (ctl_rd_data)
  );

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    ctl_init |=> (hop_valid == '0));

  assert_len_range_R9: assert property (@(posedge clk) disable iff (rst)
    (vlen_q >= LEN_W'(1)) && (vlen_q <= LEN_W'(NUM_ELEM)));

  for (genvar k = 0; k < NUM_ELEM; k++) begin : g_idle_chk
    assert_idle_elem_R5: assert property (@(posedge clk) disable iff (rst)
      (LEN_W'(k) >= vlen_q) |-> (!elem_tx_ready[k] && !elem_rx_valid[k]));
  end

endmodule

// File: tb/sim_xring.sv
module sim_xring;
  localparam int NE = 4;
  localparam int W  = 16;
  localparam int VW = $clog2(NE + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst, ctl_init, ctl_wr_valid, ctl_wr_ready, ctl_rd_valid, ctl_rd_ready;
  logic [VW-1:0] ctl_vlen;
  logic [W-1:0]  ctl_wr_data, ctl_rd_data;
  logic [NE-1:0] tx_valid, tx_ready, rx_valid, rx_ready;
  logic [NE*W-1:0] tx_data, rx_data;

  xring #(.NUM_ELEM(NE), .DATA_W(W), .HOP_DEPTH(2)) u0 (
    .clk(clk), .rst(rst), .ctl_init(ctl_init), .ctl_vlen(ctl_vlen),
    .ctl_wr_valid(ctl_wr_valid), .ctl_wr_ready(ctl_wr_ready), .ctl_wr_data(ctl_wr_data),
    .ctl_rd_valid(ctl_rd_valid), .ctl_rd_ready(ctl_rd_ready), .ctl_rd_data(ctl_rd_data),
    .elem_tx_valid(tx_valid), .elem_tx_ready(tx_ready), .elem_tx_data(tx_data),
    .elem_rx_valid(rx_valid), .elem_rx_ready(rx_ready), .elem_rx_data(rx_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // Reference: one queue per hop; hop NE is the tail toward the controller.
  logic [W-1:0] mq [NE+1][$];
  int vlen_m;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int target_of(int k);
    if (k == vlen_m - 1) return NE;
    if (k < vlen_m - 1)  return k + 1;
    return -1;
  endfunction

  task automatic step(input bit init, input int vreq, input int pv, input int pr);
    bit          pop_e [NE+1];
    bit          push_e[NE+1];
    logic [W-1:0] push_d[NE+1];
    bit          e;
    int          d;
    @(negedge clk);
    ctl_init     = init;
    ctl_vlen     = VW'(vreq);
    ctl_wr_valid = ($urandom % 100) < pv;
    ctl_wr_data  = W'($urandom);
    ctl_rd_ready = ($urandom % 100) < pr;
    for (int k = 0; k < NE; k++) begin
      tx_valid[k]       = ($urandom % 100) < pv;
      tx_data[k*W +: W] = W'($urandom);
      rx_ready[k]       = ($urandom % 100) < pr;
    end
    #1;
    for (int h = 0; h <= NE; h++) begin pop_e[h] = 0; push_e[h] = 0; push_d[h] = '0; end

    // Seed port: R2 routing, R6 capacity
    e = !init && (mq[0].size() < 2);
    chk(init ? "R9" : "R6", "ctl_wr_ready", 32'(ctl_wr_ready), 32'(e));
    if (e && ctl_wr_valid) begin push_e[0] = 1; push_d[0] = ctl_wr_data; end

    for (int k = 0; k < NE; k++) begin
      e = !init && (k < vlen_m) && (mq[k].size() > 0);
      chk(init ? "R9" : (k >= vlen_m ? "R5" : "R8"), $sformatf("rx_valid[%0d]", k),
          32'(rx_valid[k]), 32'(e));
      if (e && rx_valid[k])
        chk(k == 0 ? "R2" : "R3 R7", $sformatf("rx_data[%0d]", k),
            32'(rx_data[k*W +: W]), 32'(mq[k][0]));
      if (e && rx_ready[k]) pop_e[k] = 1;

      d = target_of(k);
      e = !init && (d >= 0) && (mq[d < 0 ? 0 : d].size() < 2);
      chk(init ? "R9" : (d < 0 ? "R5" : "R6"), $sformatf("tx_ready[%0d]", k),
          32'(tx_ready[k]), 32'(e));
      if (e && tx_valid[k]) begin push_e[d] = 1; push_d[d] = tx_data[k*W +: W]; end
    end

    e = !init && (mq[NE].size() > 0);
    chk(init ? "R9" : "R4", "ctl_rd_valid", 32'(ctl_rd_valid), 32'(e));
    if (e && ctl_rd_valid) chk("R4 R7", "ctl_rd_data", 32'(ctl_rd_data), 32'(mq[NE][0]));
    if (e && ctl_rd_ready) pop_e[NE] = 1;

    @(posedge clk);
    if (init) begin
      for (int h = 0; h <= NE; h++) mq[h].delete();
      vlen_m = (vreq < 1) ? 1 : ((vreq > NE) ? NE : vreq);
    end else begin
      for (int h = 0; h <= NE; h++) begin
        if (pop_e[h])  void'(mq[h].pop_front());
        if (push_e[h]) mq[h].push_back(push_d[h]);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired before the run completed");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int lens[6] = '{4, 2, 1, 0, 7, 3};
    rst = 1; ctl_init = 0; ctl_vlen = '0; ctl_wr_valid = 0; ctl_wr_data = '0;
    ctl_rd_ready = 0; tx_valid = '0; tx_data = '0; rx_ready = '0;
    vlen_m = NE;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R1: reset state
    chk("R1", "rx_valid",     32'(rx_valid),     32'(0));
    chk("R1", "ctl_rd_valid", 32'(ctl_rd_valid), 32'(0));
    chk("R1", "ctl_wr_ready", 32'(ctl_wr_ready), 32'(1));
    chk("R1", "tx_ready",     32'(tx_ready),     32'((1 << NE) - 1));

    for (int p = 0; p < 6; p++) begin
      step(1'b1, lens[p], 0, 0);
      for (int c = 0; c < 400; c++)
        step(1'b0, 0, (c < 200) ? 70 : 90, (c < 200) ? 80 : 25);
    end
    // Random re-initialisation under traffic
    for (int c = 0; c < 1500; c++) begin
      if (($urandom % 100) < 3) step(1'b1, int'($urandom % 8), 60, 60);
      else                      step(1'b0, 0, 60, 60);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule